// File: doc/BRIEF.md
# Signed Divide Unit with Condition Flags

This block is a multi-cycle divider for two's-complement integers, meant to sit beside a CPU execution stage. One accepted request carries a dividend, a divisor, the condition flags as they stand before the instruction, and a bit that says whether the quotient and the remainder share one destination register. Some cycles later the unit returns the quotient, the remainder, one write-enable for each, and the updated flag vector.

Requests arrive on a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. While a division is running, `in_ready` is low and `in_valid` is ignored, so the caller must hold its request until `in_ready` returns. The result side has no back-pressure. `out_done` is a one-cycle pulse, and the result ports then hold their values until the next request is accepted.

The core is a radix-2 restoring divider that works on operand magnitudes. A setup cycle comes first, then one iteration per data bit, then a cycle that applies the signs and sets the flags. A zero divisor is caught in the setup cycle and skips the iterations.

Top module: `sdiv_flags`

## Requirements
- R1: The quotient is rounded toward zero, and a nonzero remainder carries the sign of the dividend (45/-6 gives -7 rem 3; -45/6 gives -7 rem -3; -45/-6 gives 7 rem -3).
- R2: Flag S (`out_flags[1]`) equals the sign bit of the quotient, never that of the remainder.
- R3: Flag Z (`out_flags[0]`) is set exactly when the quotient is zero, whatever the remainder (16/45 gives quotient 0, remainder 16, Z set).
- R4: A zero dividend with a nonzero divisor is a normal division: quotient 0, remainder 0, Z set, OV clear, both writes enabled.
- R5: A zero divisor sets OV (`out_flags[2]`), deasserts both write-enables, and drives the quotient and remainder outputs to zero. S, Z, CY (`out_flags[3]`) and SAT (`out_flags[4]`) pass through from `in_flags` unchanged.
- R6: The most negative value divided by -1 gives quotient 0x80000000 and remainder 0, with OV and S set, and both results written.
- R7: When `in_same_dst` is 1, the quotient write-enable is low and only the remainder write is enabled. The quotient and remainder values are still reported.
- R8: For any nonzero divisor other than the R6 case, OV is cleared. CY and SAT always equal their incoming values.
- R9: `out_done` is high for exactly one cycle. With a nonzero divisor it rises on the 34th rising edge after the accepting edge; with a zero divisor it rises on the 2nd.
- R10: `in_ready` is low from the cycle after an accepted request until `out_done`. Requests offered in that window are ignored. From `out_done` until the next accepted request, all result ports hold their values.
- R11: After reset, `in_ready` is 1, and `out_done`, both write-enables, the results and the flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle; request taken when valid and ready are both high |
| in_dividend | input | W | Signed dividend |
| in_divisor | input | W | Signed divisor |
| in_flags | input | 5 | Incoming flags {SAT, CY, OV, S, Z} |
| in_same_dst | input | 1 | Quotient and remainder share one destination |
| out_done | output | 1 | One-cycle result pulse |
| out_quotient | output | W | Signed quotient |
| out_remainder | output | W | Signed remainder |
| out_q_we | output | 1 | Write-enable for the quotient |
| out_r_we | output | 1 | Write-enable for the remainder |
| out_flags | output | 5 | Updated flags {SAT, CY, OV, S, Z} |

## Verification
The bench builds the unit with W = 32, its default. At this width the single overflowing pair (0x80000000 by -1) can be applied directly, and the 32-step iteration latency can be counted edge by edge. Table vectors cover every sign combination, both zero-divisor flag states, the shared-destination case and flag pass-through. Directed tests then cover reset values, a request offered while the unit is busy, and holding the results after completion.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef struct packed {
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } flags_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ITER,
    ST_FIN
  } st_e;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic div_zero,
  output st_e  state,
  output logic load,
  output logic step,
  output logic fin
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (accept) state <= ST_SETUP;
        ST_SETUP: begin
          cnt   <= '0;
          state <= div_zero ? ST_FIN : ST_ITER;
        end
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load = (state == ST_SETUP) && !div_zero;
    step = (state == ST_ITER);
    fin  = (state == ST_FIN);
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  logic [W-1:0] dvs_r;
  logic [W:0]   shifted;
  logic [W:0]   trial;

  always_comb begin
    shifted = {rem_mag, quo_mag[W-1]};
    trial   = shifted - {1'b0, dvs_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_mag <= '0;
      rem_mag <= '0;
      dvs_r   <= '0;
    end else if (load) begin
      quo_mag <= dvd_mag;
      rem_mag <= '0;
      dvs_r   <= dvs_mag;
    end else if (step) begin
      if (!trial[W]) begin
        rem_mag <= trial[W-1:0];
        quo_mag <= {quo_mag[W-2:0], 1'b1};
      end else begin
        rem_mag <= shifted[W-1:0];
        quo_mag <= {quo_mag[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         dvd_neg,
  input  logic         dvs_neg,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         div_zero,
  input  logic         min_by_m1,
  input  logic         same_dst,
  input  flags_t       flg_in,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         q_we,
  output logic         r_we,
  output flags_t       flg_out
);
  logic [W-1:0] q_signed;

  always_comb begin
    q_signed = (dvd_neg ^ dvs_neg) ? (~quo_mag + 1'b1) : quo_mag;
    flg_out  = flg_in;
    if (div_zero) begin
      quo        = '0;
      rem        = '0;
      q_we       = 1'b0;
      r_we       = 1'b0;
      flg_out.ov = 1'b1;
    end else begin
      quo        = q_signed;
      rem        = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
      q_we       = !same_dst;
      r_we       = 1'b1;
      flg_out.ov = min_by_m1;
      flg_out.s  = q_signed[W-1];
      flg_out.z  = (q_signed == '0);
    end
  end
endmodule

// File: rtl/sdiv_flags.sv
module sdiv_flags
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  input  logic [4:0]   in_flags,
  input  logic         in_same_dst,
  output logic         out_done,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder,
  output logic         out_q_we,
  output logic         out_r_we,
  output logic [4:0]   out_flags
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  st_e          state;
  logic         accept, load, step, fin;
  logic [W-1:0] dvd_q, dvs_q;
  flags_t       flg_q;
  logic         same_q;
  logic         div_zero, min_by_m1;
  logic [W-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag;
  logic [W-1:0] quo_w, rem_w;
  logic         q_we_w, r_we_w;
  flags_t       flg_w;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      flg_q  <= '0;
      same_q <= 1'b0;
    end else if (accept) begin
      dvd_q  <= in_dividend;
      dvs_q  <= in_divisor;
      flg_q  <= flags_t'(in_flags);
      same_q <= in_same_dst;
    end
  end

  always_comb begin
    div_zero  = (dvs_q == '0);
    min_by_m1 = (dvd_q == MOST_NEG) && (dvs_q == '1);
    dvd_mag   = dvd_q[W-1] ? (~dvd_q + 1'b1) : dvd_q;
    dvs_mag   = dvs_q[W-1] ? (~dvs_q + 1'b1) : dvs_q;
  end

  sdiv_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .div_zero (div_zero),
    .state    (state),
    .load     (load),
    .step     (step),
    .fin      (fin)
  );

  sdiv_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .quo_mag (quo_mag),
    .rem_mag (rem_mag)
  );

  sdiv_fixup #(.W(W)) u_fix (
    .dvd_neg   (dvd_q[W-1]),
    .dvs_neg   (dvs_q[W-1]),
    .quo_mag   (quo_mag),
    .rem_mag   (rem_mag),
    .div_zero  (div_zero),
    .min_by_m1 (min_by_m1),
    .same_dst  (same_q),
    .flg_in    (flg_q),
    .quo       (quo_w),
    .rem       (rem_w),
    .q_we      (q_we_w),
    .r_we      (r_we_w),
    .flg_out   (flg_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done      <= 1'b0;
      out_quotient  <= '0;
      out_remainder <= '0;
      out_q_we      <= 1'b0;
      out_r_we      <= 1'b0;
      out_flags     <= '0;
    end else begin
      out_done <= fin;
      if (fin) begin
        out_quotient  <= quo_w;
        out_remainder <= rem_w;
        out_q_we      <= q_we_w;
        out_r_we      <= r_we_w;
        out_flags     <= flg_w;
      end
    end
  end
endmodule

// File: rtl/sdiv_flags_chk.sv
module sdiv_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_done,
  input logic [W-1:0] out_quotient,
  input logic [W-1:0] out_remainder,
  input logic         out_q_we,
  input logic         out_r_we,
  input logic [4:0]   out_flags,
  input logic [4:0]   held_flags
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r10_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);

  a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !out_done) |=>
      ($stable(out_quotient) && $stable(out_remainder) && $stable(out_flags)
       && $stable(out_q_we) && $stable(out_r_we)));

  a_r2_sign_from_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_r_we) |-> (out_flags[1] == out_quotient[W-1]));

  a_r3_zero_from_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_r_we) |-> (out_flags[0] == (out_quotient == '0)));

  a_r5_no_write_means_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_r_we) |-> (out_flags[2] && !out_q_we));

  a_r7_quotient_needs_remainder: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_q_we) |-> out_r_we);

  a_r8_cy_sat_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_flags[4:3] == held_flags[4:3]));
endmodule

bind sdiv_flags sdiv_flags_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_done      (out_done),
  .out_quotient  (out_quotient),
  .out_remainder (out_remainder),
  .out_q_we      (out_q_we),
  .out_r_we      (out_r_we),
  .out_flags     (out_flags),
  .held_flags    (flg_q)
);

// File: tb/sdiv_flags_bench.sv
module sdiv_flags_bench;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 13;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [4:0]   fi;
    logic         sd;
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         qwe;
    logic         rwe;
    logic [4:0]   fo;
  } vec_t;

  // flags {SAT,CY,OV,S,Z}
  localparam vec_t VECS [NV] = '{
    '{32'd45, 32'd6, 5'b00000, 1'b0, 32'd7, 32'd3, 1'b1, 1'b1, 5'b00000},            // R1
    '{32'd45, -32'sd6, 5'b00000, 1'b0, -32'sd7, 32'd3, 1'b1, 1'b1, 5'b00010},         // R1 R2
    '{-32'sd45, 32'd6, 5'b00000, 1'b0, -32'sd7, -32'sd3, 1'b1, 1'b1, 5'b00010},       // R1 R2
    '{-32'sd45, -32'sd6, 5'b00000, 1'b0, 32'd7, -32'sd3, 1'b1, 1'b1, 5'b00000},       // R1 R2
    '{32'd45, 32'd0, 5'b00000, 1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 5'b00100},             // R5
    '{32'd45, 32'd0, 5'b11111, 1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 5'b11111},             // R5
    '{32'd0, 32'd45, 5'b00000, 1'b0, 32'd0, 32'd0, 1'b1, 1'b1, 5'b00001},             // R4
    '{32'h80000000, 32'hFFFFFFFF, 5'b00000, 1'b0, 32'h80000000, 32'd0, 1'b1, 1'b1, 5'b00110}, // R6
    '{32'd16, 32'd45, 5'b00000, 1'b0, 32'd0, 32'd16, 1'b1, 1'b1, 5'b00001},           // R3
    '{32'd45, 32'd6, 5'b00000, 1'b1, 32'd7, 32'd3, 1'b0, 1'b1, 5'b00000},             // R7
    '{32'd45, 32'd6, 5'b11111, 1'b0, 32'd7, 32'd3, 1'b1, 1'b1, 5'b11000},             // R8
    '{32'h80000000, 32'd1, 5'b00000, 1'b0, 32'h80000000, 32'd0, 1'b1, 1'b1, 5'b00010}, // R2
    '{32'h7FFFFFFF, 32'd2, 5'b00000, 1'b0, 32'h3FFFFFFF, 32'd1, 1'b1, 1'b1, 5'b00000}  // R1
  };

  function automatic string vreq(int i);
    case (i)
      4, 5:    return "R5";
      6:       return "R4";
      7:       return "R6";
      8:       return "R3";
      9:       return "R7";
      10:      return "R8";
      11:      return "R2";
      default: return "R1";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic [4:0]   in_flags = '0;
  logic         in_same_dst = 1'b0;
  logic         out_done;
  logic [W-1:0] out_quotient, out_remainder;
  logic         out_q_we, out_r_we;
  logic [4:0]   out_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdiv_flags #(.W(W)) u_sdiv_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_flags(in_flags),
    .in_same_dst(in_same_dst), .out_done(out_done), .out_quotient(out_quotient),
    .out_remainder(out_remainder), .out_q_we(out_q_we), .out_r_we(out_r_we),
    .out_flags(out_flags)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Offer one request at a negedge, count edges until out_done is seen.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [4:0] f, input logic sd, output int lat);
    in_dividend = a; in_divisor = b; in_flags = f; in_same_dst = sd;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!out_done && lat < 100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lat;
    logic [W-1:0] hq;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
    chk(out_done == 1'b0 && out_q_we == 1'b0 && out_r_we == 1'b0, "R11", "done/we",
        {out_done, out_q_we, out_r_we}, 0);
    chk(out_quotient == '0 && out_flags == '0, "R11", "results", {out_quotient, 27'd0, out_flags}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].a, VECS[i].b, VECS[i].fi, VECS[i].sd, lat);
      chk(out_quotient == VECS[i].q, vreq(i), "quotient", out_quotient, VECS[i].q);
      chk(out_remainder == VECS[i].r, vreq(i), "remainder", out_remainder, VECS[i].r);
      chk({out_q_we, out_r_we} == {VECS[i].qwe, VECS[i].rwe}, vreq(i), "write enables",
          {out_q_we, out_r_we}, {VECS[i].qwe, VECS[i].rwe});
      chk(out_flags == VECS[i].fo, vreq(i), "flags", out_flags, VECS[i].fo);
      // R9 latency
      chk(lat == ((VECS[i].b == '0) ? 2 : 34), "R9", "latency", lat,
          (VECS[i].b == '0) ? 2 : 34);
      @(negedge clk);
      chk(out_done == 1'b0, "R9", "done width", out_done, 0);
    end

    // R10: request offered while busy is ignored
    in_dividend = 32'd100; in_divisor = 32'd7; in_flags = '0; in_same_dst = 1'b0;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0, "R10", "busy ready", in_ready, 0);
    in_dividend = 32'd1; in_divisor = 32'd1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(out_quotient == 32'd14 && out_remainder == 32'd2, "R10", "busy request ignored",
        {out_quotient, out_remainder}, {32'd14, 32'd2});
    hq = out_quotient;
    repeat (40) begin
      @(negedge clk);
      if (out_done) lat = -1;
    end
    chk(lat != -1, "R10", "no second result", lat, 0);
    chk(out_quotient == hq && out_remainder == 32'd2 && out_flags == 5'b00000,
        "R10", "results held", out_quotient, hq);
    chk(in_ready == 1'b1, "R10", "ready after done", in_ready, 1);

    finish_run();
  end
endmodule